// File: doc/BRIEF.md
# Two-Slave SPI Index Poller

This block is an SPI bus master that polls two slave devices sharing one serial clock, one MOSI line and one MISO line, each slave having its own active-low select. Each burst addresses one slave and sends it a fixed, increasing run of index bytes that starts at zero, stops at a top index, and closes with an end marker byte. Bursts start on a fixed slot grid and serve the slaves in turn (ping-pong), so that one full round covers both slaves within the polling period.

The serial clock idles high. Data leaves the master on falling edges and is taken on rising edges, most significant bit first. The select of the addressed slave falls half a clock period before the first falling edge of a byte. It rises half a period after the rising edge that takes the eighth bit, so no edge of a following byte can ever be seen by the slave. Between bytes both selects and the clock stay high for one full byte time. Each returned byte appears on a receive stream as a one-cycle valid pulse with the byte, the slave number and the index that was being sent. The stream has no ready input. The bus timing is fixed by the divider and cannot stall, so the consumer must take every pulse in the cycle it appears.

The clock divider ratio and the slot length are derived from the system clock, serial clock and polling rate parameters.

Top module: `spi_index_poller`

## Requirements
- R1: While reset is held and in the first cycle after it, both selects are high, SCK is high, MOSI is low and the receive valid is low.
- R2: Within a byte, SCK toggles every HALF_DIV cycles, where HALF_DIV = CLK_HZ/(2*SCK_HZ). MOSI changes only on falling edges and is sampled by the slave on rising edges, MSB first. Whenever no select is low, SCK is high.
- R3: A select falls only while SCK is high, and the first SCK edge after it is a falling edge, HALF_DIV cycles later.
- R4: A select rises while SCK is high, HALF_DIV cycles after the eighth rising edge of that byte, and exactly eight rising edges occur while it is low.
- R5: Each burst sends the bytes 0x00, 0x01, ... up to LAST_IDX (default 0x26), each one more than the last, and then END_MARK (default 0xFF), after which the burst ends.
- R6: Between two bytes of one burst, the select stays high for exactly 16*HALF_DIV cycles, with SCK idle high.
- R7: At most one select is low at a time. Bursts start every SLOT_CYC = CLK_HZ/POLL_HZ/NUM_SLV cycles and serve slave 0, then 1, then 0 again. The first burst after reset goes to slave 0 and starts in the first cycle out of reset.
- R8: In the cycle after the eighth rising edge, rx_valid is high for exactly one cycle. rx_data holds the eight MISO bits, the first sampled bit in bit 7. rx_slave holds the slave number (0 or 1) and rx_index holds the byte sent in that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| miso | input | 1 | Shared serial data from the slaves |
| sck | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data to the slaves |
| csn_n | output | NUM_SLV | Active-low select, one bit per slave |
| rx_valid | output | 1 | One-cycle pulse: a returned byte is present |
| rx_data | output | 8 | Byte returned by the slave |
| rx_slave | output | SLV_W | Slave that returned the byte |
| rx_index | output | 8 | Index byte sent during that transfer |

## Verification
The hardest moments to reach are the end of a burst and the handoff to the other slave. The index must wrap from the top value to the end marker, the burst must stop with no gap, and the next select must fall on the slot boundary. None of this happens until a whole burst of forty bytes has run. The bench shrinks the divider to two cycles per half period and the slot to three thousand cycles, then runs two complete rounds. It models both slaves, and each returns a distinct per-slave pattern. That lets it catch a swapped slave number, a shifted bit or a skipped index in the middle of a round.

// File: rtl/spi_poll_pkg.sv
package spi_poll_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_SHIFT,
    PH_TRAIL,
    PH_GAP
  } phase_e;

  localparam int BITS_PER_BYTE = 8;
  // idle time between bytes equals one full byte (two halves per bit)
  localparam int GAP_HALVES    = 2 * BITS_PER_BYTE;

endpackage

// File: rtl/spi_poll_halfdiv.sv
module spi_poll_halfdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)   cnt <= CW'(HALF_DIV - 1);
    else if (cnt == '0)   cnt <= CW'(HALF_DIV - 1);
    else                  cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0) && !restart;
endmodule

// File: rtl/spi_poll_sched.sv
module spi_poll_sched #(
  parameter int SLOT_CYC = 3000,
  parameter int NUM_SLV  = 2,
  parameter int SLV_W    = 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic             start,
  output logic [SLV_W-1:0] slot_slv
);
  localparam int PW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [PW-1:0]    pcnt;
  logic [SLV_W-1:0] slv;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      slv  <= '0;
    end else begin
      if (pcnt == PW'(SLOT_CYC - 1)) pcnt <= '0;
      else                           pcnt <= pcnt + 1'b1;
      if (pcnt == '0) begin
        if (slv == SLV_W'(NUM_SLV - 1)) slv <= '0;
        else                            slv <= slv + 1'b1;
      end
    end
  end

  assign start    = (pcnt == '0);
  assign slot_slv = slv;
endmodule

// File: rtl/spi_poll_engine.sv
module spi_poll_engine
  import spi_poll_pkg::*;
#(
  parameter int          NUM_SLV  = 2,
  parameter int          SLV_W    = 1,
  parameter logic [7:0]  LAST_IDX = 8'h26,
  parameter logic [7:0]  END_MARK = 8'hFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [SLV_W-1:0]   start_slv,
  input  logic               tick,
  input  logic               miso,
  output logic               restart,
  output logic               sck,
  output logic               mosi,
  output logic [NUM_SLV-1:0] csn_n,
  output logic               rx_valid,
  output logic [7:0]         rx_data,
  output logic [SLV_W-1:0]   rx_slave,
  output logic [7:0]         rx_index
);
  localparam int GW = $clog2(GAP_HALVES);

  phase_e           phase;
  logic             active;
  logic [SLV_W-1:0] act;
  logic [7:0]       cur, tx, rx;
  logic [2:0]       bcnt;
  logic [GW-1:0]    gcnt;
  logic [7:0]       nxt, rx_next;

  assign restart = (phase == PH_IDLE) && start;
  assign nxt     = (cur == LAST_IDX) ? END_MARK : cur + 8'd1;
  assign rx_next = {rx[6:0], miso};

  // one select per slave, low only for the addressed one
  for (genvar gi = 0; gi < NUM_SLV; gi++) begin : g_sel
    assign csn_n[gi] = !(active && (act == SLV_W'(gi)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      active   <= 1'b0;
      act      <= '0;
      cur      <= '0;
      tx       <= '0;
      rx       <= '0;
      bcnt     <= '0;
      gcnt     <= '0;
      sck      <= 1'b1;
      mosi     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_slave <= '0;
      rx_index <= '0;
    end else begin
      rx_valid <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_LEAD;
          active <= 1'b1;
          act    <= start_slv;
          cur    <= '0;
          tx     <= '0;
        end
        PH_LEAD: if (tick) begin
          sck   <= 1'b0;
          mosi  <= tx[7];
          tx    <= {tx[6:0], 1'b0};
          bcnt  <= '0;
          phase <= PH_SHIFT;
        end
        PH_SHIFT: if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
            rx  <= rx_next;
            if (bcnt == 3'd7) begin
              phase    <= PH_TRAIL;
              rx_valid <= 1'b1;
              rx_data  <= rx_next;
              rx_slave <= act;
              rx_index <= cur;
            end else begin
              bcnt <= bcnt + 3'd1;
            end
          end else begin
            sck  <= 1'b0;
            mosi <= tx[7];
            tx   <= {tx[6:0], 1'b0};
          end
        end
        PH_TRAIL: if (tick) begin
          active <= 1'b0;
          gcnt   <= '0;
          phase  <= (cur == END_MARK) ? PH_IDLE : PH_GAP;
        end
        PH_GAP: if (tick) begin
          if (gcnt == GW'(GAP_HALVES - 1)) begin
            phase  <= PH_LEAD;
            active <= 1'b1;
            cur    <= nxt;
            tx     <= nxt;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_index_poller.sv
module spi_index_poller #(
  parameter int         CLK_HZ   = 100_000_000,
  parameter int         SCK_HZ   = 40_000,
  parameter int         POLL_HZ  = 10,
  parameter int         NUM_SLV  = 2,
  parameter logic [7:0] LAST_IDX = 8'h26,
  parameter logic [7:0] END_MARK = 8'hFF,
  localparam int        SLV_W    = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic [NUM_SLV-1:0] csn_n,
  output logic               rx_valid,
  output logic [7:0]         rx_data,
  output logic [SLV_W-1:0]   rx_slave,
  output logic [7:0]         rx_index
);
  localparam int HALF_DIV   = CLK_HZ / (2 * SCK_HZ);
  localparam int PERIOD_CYC = CLK_HZ / POLL_HZ;
  localparam int SLOT_CYC   = PERIOD_CYC / NUM_SLV;

  logic             start, tick, restart;
  logic [SLV_W-1:0] slot_slv;

  spi_poll_sched #(
    .SLOT_CYC (SLOT_CYC),
    .NUM_SLV  (NUM_SLV),
    .SLV_W    (SLV_W)
  ) u_sched (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .slot_slv (slot_slv)
  );

  spi_poll_halfdiv #(
    .HALF_DIV (HALF_DIV)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick)
  );

  spi_poll_engine #(
    .NUM_SLV  (NUM_SLV),
    .SLV_W    (SLV_W),
    .LAST_IDX (LAST_IDX),
    .END_MARK (END_MARK)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_slv (slot_slv),
    .tick      (tick),
    .miso      (miso),
    .restart   (restart),
    .sck       (sck),
    .mosi      (mosi),
    .csn_n     (csn_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_slave  (rx_slave),
    .rx_index  (rx_index)
  );
endmodule

// File: rtl/spi_index_poller_chk.sv
module spi_index_poller_chk #(
  parameter int         NUM_SLV  = 2,
  parameter logic [7:0] LAST_IDX = 8'h26,
  parameter logic [7:0] END_MARK = 8'hFF
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SLV-1:0] csn_n,
  input logic               sck,
  input logic               rx_valid,
  input logic [7:0]         rx_index
);
  logic sel_any;
  assign sel_any = ~&csn_n;

  // R7
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~csn_n));

  // R2
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_any |-> sck);

  // R3
  select_fall_on_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_any) |-> sck);

  // R4
  select_rise_on_high_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_any) |-> sck);

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (sel_any && sck));

  // R5
  index_range_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_index <= LAST_IDX) || (rx_index == END_MARK)));
endmodule

bind spi_index_poller spi_index_poller_chk #(
  .NUM_SLV  (NUM_SLV),
  .LAST_IDX (LAST_IDX),
  .END_MARK (END_MARK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .csn_n    (csn_n),
  .sck      (sck),
  .rx_valid (rx_valid),
  .rx_index (rx_index)
);

// File: tb/tb_spi_index_poller.sv
module tb_spi_index_poller;
  localparam int H     = 2;
  localparam int SLOT  = 3000;
  localparam int NBYTE = 40;
  localparam int TOTAL = 4 * NBYTE;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       miso = 1'b1;
  logic       sck, mosi, rx_valid;
  logic [1:0] csn_n;
  logic [7:0] rx_data, rx_index;
  logic [0:0] rx_slave;

  always #5 clk = ~clk;

  spi_index_poller #(
    .CLK_HZ (240_000),
    .SCK_HZ (60_000),
    .POLL_HZ(40)
  ) dut (
    .clk(clk), .rst(rst), .miso(miso), .sck(sck), .mosi(mosi),
    .csn_n(csn_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_slave(rx_slave), .rx_index(rx_index)
  );

  typedef struct packed {
    logic       s;
    logic [7:0] idx;
    logic [7:0] data;
  } item_t;

  item_t expq[$];
  int checks = 0;
  int errors = 0;
  int strobes = 0;
  int idle_bad = 0;

  function automatic logic [7:0] idx_of(int n);
    return (n == NBYTE - 1) ? 8'hFF : 8'(n);
  endfunction

  function automatic logic [7:0] resp(int s, int n);
    return idx_of(n) ^ ((s == 0) ? 8'h96 : 8'h5A);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: expected returned bytes for two full rounds
  task automatic push_burst(int s);
    for (int n = 0; n < NBYTE; n++) begin
      item_t it;
      it.s    = s[0];
      it.idx  = idx_of(n);
      it.data = resp(s, n);
      expq.push_back(it);
    end
  endtask

  // monitor, slave models and scoreboard
  initial begin
    int cyc = 0;
    logic psck = 1'b1;
    logic [1:0] psel = 2'b00;
    logic [1:0] sel;
    int last_edge = 0, fall_cyc = 0, rises = 0;
    int last_rise = -100000, burst_start = -1, burst_slv = -1;
    bit first_pend = 0, pvld = 0;
    int s_cnt[2] = '{0, 0};
    logic [7:0] s_tx[2];
    logic [7:0] s_rx[2];
    int cs = 0;
    wait (!rst);
    forever begin
      @(negedge clk);
      cyc++;
      sel = ~csn_n;
      for (int s = 0; s < 2; s++) begin
        if (!psel[s] && sel[s]) begin
          chk(sck == 1'b1, "R3", "sck at select fall", sck, 1);
          chk(sel != 2'b11, "R7", "two selects low", sel, 1);
          if (cyc - last_rise < 100) begin
            chk(cyc - last_rise == 16 * H, "R6", "inter-byte gap", cyc - last_rise, 16 * H);
          end else begin
            if (burst_start < 0) begin
              chk(s == 0 && cyc == 1, "R7", "first burst slave/cycle", s * 1000 + cyc, 1);
            end else begin
              chk(cyc - burst_start == SLOT, "R7", "burst spacing", cyc - burst_start, SLOT);
              chk(s != burst_slv, "R7", "ping-pong slave", s, 1 - burst_slv);
            end
            burst_start = cyc;
            burst_slv = s;
          end
          cs = s;
          s_tx[s] = resp(s, s_cnt[s]);
          rises = 0;
          first_pend = 1;
          fall_cyc = cyc;
        end
      end
      if (sel != 2'b00 && psck && !sck) begin
        if (first_pend) chk(cyc - fall_cyc == H, "R3", "lead to first fall", cyc - fall_cyc, H);
        else            chk(cyc - last_edge == H, "R2", "half period fall", cyc - last_edge, H);
        first_pend = 0;
        last_edge = cyc;
        miso = s_tx[cs][7];
        s_tx[cs] = {s_tx[cs][6:0], 1'b0};
      end
      if (sel != 2'b00 && !psck && sck) begin
        chk(cyc - last_edge == H, "R2", "half period rise", cyc - last_edge, H);
        rises++;
        s_rx[cs] = {s_rx[cs][6:0], mosi};
        last_edge = cyc;
      end
      for (int s = 0; s < 2; s++) begin
        if (psel[s] && !sel[s]) begin
          chk(sck == 1'b1, "R4", "sck at select rise", sck, 1);
          chk(rises == 8, "R4", "rising edges in byte", rises, 8);
          chk(cyc - last_edge == H, "R4", "trail after 8th rise", cyc - last_edge, H);
          chk(s_rx[s] == idx_of(s_cnt[s]), "R5", "index on MOSI", s_rx[s], idx_of(s_cnt[s]));
          s_cnt[s] = (s_cnt[s] + 1) % NBYTE;
          last_rise = cyc;
        end
      end
      if (sel == 2'b00 && !sck) idle_bad++;
      if (rx_valid) begin
        strobes++;
        chk(!pvld, "R8", "strobe width", 2, 1);
        chk(rises == 8 && cyc == last_edge, "R8", "strobe timing", cyc - last_edge, 0);
        if (expq.size() == 0) begin
          chk(0, "R8", "unexpected strobe", rx_data, 0);
        end else begin
          item_t e;
          e = expq.pop_front();
          chk(rx_data == e.data, "R8", "rx_data", rx_data, e.data);
          chk(rx_slave[0] == e.s, "R8", "rx_slave", rx_slave, e.s);
          chk(rx_index == e.idx, "R5", "rx_index", rx_index, e.idx);
        end
      end
      pvld = rx_valid;
      psel = sel;
      psck = sck;
    end
  end

  initial begin
    bit done = 0;
    push_burst(0);
    push_burst(1);
    push_burst(0);
    push_burst(1);
    repeat (5) @(negedge clk);
    chk(csn_n == 2'b11, "R1", "selects in reset", csn_n, 3);
    chk(sck == 1'b1, "R1", "sck in reset", sck, 1);
    chk(mosi == 1'b0, "R1", "mosi in reset", mosi, 0);
    chk(rx_valid == 1'b0, "R1", "valid in reset", rx_valid, 0);
    rst = 1'b0;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (strobes >= TOTAL) begin
        done = 1;
        break;
      end
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d strobes expected %0d", strobes, TOTAL);
    end
    repeat (200) @(negedge clk);
    chk(idle_bad == 0, "R2", "sck low while deselected", idle_bad, 0);
    chk(expq.size() == 0, "R8", "items left in scoreboard", expq.size(), 0);
    chk(strobes == TOTAL, "R5", "strobes in two rounds", strobes, TOTAL);
    chk(csn_n == 2'b11, "R7", "bus idle between slots", csn_n, 3);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule